// File: doc/BRIEF.md
# Center-Aligned PWM Timebase Channel

This block is one channel of a symmetrical pulse-width modulator. A triangle counter climbs from zero to a programmable peak and falls back to zero, one step per timebase tick, so a full carrier cycle lasts twice the peak value in ticks. Each compare output is raised when the rising counter reaches its compare value and dropped when the falling counter reaches it again. The result is a pulse centred on the carrier peak.

Software writes the peak, the compare values and the phase through a simple write port. The peak and the compare values are double-buffered: a write lands in a holding register and takes effect only when the counter sits at zero. This keeps a carrier cycle from being cut or stretched part-way through.

Several channels can be chained. A leader channel emits a one-cycle synchronisation pulse at its zero point and pays no attention to its own sync input. A follower forwards its sync input unchanged and, on each sync pulse, jumps to its phase value and counts upward. A decimating event counter raises an interrupt pulse on every Nth zero point and keeps a sticky flag that software clears with a write.

Top module: `cpwm_channel`

## Requirements
- R1: After reset the counter is 0, every compare output is 0, the interrupt pulse and flag are 0, and no synchronisation pulse is driven while no tick arrives.
- R2: When the peak P is greater than 0, the counter advances by one step on every tick. It runs 0,1,…,P,P-1,…,1,0 and repeats, turning at P and at 0 without repeating either end value.
- R3: In a cycle without a tick (and without a follower sync pulse) the counter holds its value.
- R4: A peak written at address 0 is held until the tick at which the counter is 0. Only from that point does it govern the turning point, so a carrier cycle already under way finishes with the old peak.
- R5: Compare i is written at address 1+i (A at 1, B at 2) and is applied at the zero point like the peak. Output i goes to 1 when an upward step lands on compare i, and goes to 0 when a downward step lands on it. A compare equal to the peak therefore only sets the output.
- R6: A compare value of 0, or one greater than the active peak, never matches, and the output keeps its state.
- R7: A leader channel drives sync_out high, combinationally, exactly in the cycles where a tick arrives while its counter is 0.
- R8: A follower channel copies sync_in to sync_out. In a cycle with sync_in high it loads the phase value written at address 3 into the counter and continues counting upward, whether or not a tick arrives.
- R9: Every EVT_N-th zero point (3 by default) raises irq_pulse for one cycle and sets irq_flag. A write to address 4 clears irq_flag, and a set in the same cycle wins over the clear.
- R10: A leader channel ignores sync_in, so its counter is not disturbed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase tick enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 peak, 1+i compare i, NUM_CMP+1 phase, NUM_CMP+2 flag clear |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Synchronisation input (used by followers) |
| pwm_raw | output | NUM_CMP | Compare outputs before dead-band shaping |
| sync_out | output | 1 | Synchronisation output to the next channel |
| irq_pulse | output | 1 | One-cycle decimated interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| count | output | CNT_W | Current counter value |

## Verification
The bench shortens the peak while the counter is climbing. A design that loads the peak at once would turn early, and the largest value seen in that cycle would fall short of the old peak. Compares equal to the peak are used to latch the outputs high, and compares of 0 or above the peak are then written to show that the outputs stay high. A design that matched at zero or out of range would drop them. A sync pulse is applied to the leader in mid-climb, where a wrong phase load would send the count back to the phase value. Six whole carrier cycles are counted against exactly two interrupt pulses, which catches a decimator that is off by one.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cpwm_dir_e;

   // register map: peak first, then one slot per compare, then phase, then flag clear
   function automatic int cpwm_addr_cmp(input int idx);
      return 1 + idx;
   endfunction

   function automatic int cpwm_addr_phase(input int n_cmp);
      return 1 + n_cmp;
   endfunction

   function automatic int cpwm_addr_clr(input int n_cmp);
      return 2 + n_cmp;
   endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sync_ld,
   input  logic [CNT_W-1:0] phase,
   input  logic [CNT_W-1:0] prd_eff,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step,
   output logic             step_up,
   output logic             zero_evt
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   cpwm_dir_e dir_q, dir_d;

   always_comb begin
      cnt_nxt = cnt;
      dir_d   = dir_q;
      if (sync_ld) begin
         cnt_nxt = phase;
         dir_d   = DIR_UP;
      end else if (tick && prd_eff != ZERO) begin
         if (dir_q == DIR_UP) begin
            if (cnt >= prd_eff) begin
               cnt_nxt = cnt - ONE;
               dir_d   = DIR_DOWN;
            end else begin
               cnt_nxt = cnt + ONE;
            end
         end else begin
            if (cnt == ZERO) begin
               cnt_nxt = ONE;
               dir_d   = DIR_UP;
            end else begin
               cnt_nxt = cnt - ONE;
            end
         end
      end
   end

   assign zero_evt = tick && !sync_ld && (cnt == ZERO);
   assign step     = tick && !sync_ld && (cnt_nxt != cnt);
   assign step_up  = (cnt_nxt > cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= ZERO;
         dir_q <= DIR_UP;
      end else begin
         cnt   <= cnt_nxt;
         dir_q <= dir_d;
      end
   end

endmodule

// File: rtl/cpwm_shadow_regs.sv
module cpwm_shadow_regs
   import cpwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_CMP = 2,
   parameter int ADDR_W  = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [CNT_W-1:0]                wr_data,
   input  logic                            zero_evt,
   output logic [CNT_W-1:0]                prd_eff,
   output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_eff,
   output logic [CNT_W-1:0]                phase
);

   localparam logic [ADDR_W-1:0] A_PRD   = '0;
   localparam logic [ADDR_W-1:0] A_PHASE = ADDR_W'(cpwm_addr_phase(NUM_CMP));

   logic [CNT_W-1:0] prd_hold, prd_live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prd_hold <= '0;
         prd_live <= '0;
         phase    <= '0;
      end else begin
         if (wr_en && wr_addr == A_PRD)   prd_hold <= wr_data;
         if (wr_en && wr_addr == A_PHASE) phase    <= wr_data;
         if (zero_evt)                    prd_live <= prd_hold;
      end
   end

   // the value in force for the step taken at a zero point is the freshly loaded one
   assign prd_eff = zero_evt ? prd_hold : prd_live;

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(cpwm_addr_cmp(gi));
      logic [CNT_W-1:0] cmp_hold, cmp_live;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_hold <= '0;
            cmp_live <= '0;
         end else begin
            if (wr_en && wr_addr == A_CMP) cmp_hold <= wr_data;
            if (zero_evt)                  cmp_live <= cmp_hold;
         end
      end

      assign cmp_eff[gi] = zero_evt ? cmp_hold : cmp_live;
   end

endmodule

// File: rtl/cpwm_action.sv
module cpwm_action #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             step_up,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] prd,
   output logic             pwm
);

   logic hit;

   assign hit = step && (cnt_nxt == cmp) && (cmp != '0) && (cmp <= prd);

   always_ff @(posedge clk) begin
      if (!rst_n)   pwm <= 1'b0;
      else if (hit) pwm <= step_up;
   end

endmodule

// File: rtl/cpwm_evt_presc.sv
module cpwm_evt_presc #(
   parameter int EVT_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_evt,
   input  logic flag_clr,
   output logic irq_pulse,
   output logic irq_flag
);

   localparam int EW = (EVT_N > 2) ? $clog2(EVT_N) : 1;
   localparam logic [EW-1:0] LAST = EW'(EVT_N - 1);

   logic [EW-1:0] evt_cnt;
   logic          fire;

   assign fire = zero_evt && (evt_cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_cnt   <= '0;
         irq_pulse <= 1'b0;
         irq_flag  <= 1'b0;
      end else begin
         irq_pulse <= fire;
         if (zero_evt) evt_cnt <= fire ? '0 : evt_cnt + EW'(1);
         if (fire)          irq_flag <= 1'b1;
         else if (flag_clr) irq_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
   import cpwm_pkg::*;
#(
   parameter  int CNT_W   = 16,
   parameter  int NUM_CMP = 2,
   parameter  int EVT_N   = 3,
   parameter  bit MASTER  = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_CMP + 3)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic               sync_in,
   output logic [NUM_CMP-1:0] pwm_raw,
   output logic               sync_out,
   output logic               irq_pulse,
   output logic               irq_flag,
   output logic [CNT_W-1:0]   count
);

   if (CNT_W < 2)   begin : g_bad_width $error("cpwm_channel: CNT_W must be at least 2"); end
   if (NUM_CMP < 1) begin : g_bad_cmp   $error("cpwm_channel: NUM_CMP must be at least 1"); end
   if (EVT_N < 2)   begin : g_bad_evt   $error("cpwm_channel: EVT_N must be at least 2"); end

   localparam bit                PHASE_EN = !MASTER;
   localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(cpwm_addr_clr(NUM_CMP));

   logic                          sync_ld, zero_evt, step, step_up;
   logic [CNT_W-1:0]              cnt_nxt, prd_eff, phase;
   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_eff;

   assign sync_ld = PHASE_EN && sync_in;

   cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sync_ld(sync_ld),
      .phase(phase), .prd_eff(prd_eff), .cnt(count), .cnt_nxt(cnt_nxt),
      .step(step), .step_up(step_up), .zero_evt(zero_evt)
   );

   cpwm_shadow_regs #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .zero_evt(zero_evt), .prd_eff(prd_eff),
      .cmp_eff(cmp_eff), .phase(phase)
   );

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_act
      cpwm_action #(.CNT_W(CNT_W)) u_act (
         .clk(clk), .rst_n(rst_n), .step(step), .step_up(step_up),
         .cnt_nxt(cnt_nxt), .cmp(cmp_eff[gi]), .prd(prd_eff), .pwm(pwm_raw[gi])
      );
   end

   cpwm_evt_presc #(.EVT_N(EVT_N)) u_evt (
      .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt),
      .flag_clr(wr_en && wr_addr == A_CLR),
      .irq_pulse(irq_pulse), .irq_flag(irq_flag)
   );

   if (MASTER) begin : g_leader
      assign sync_out = zero_evt;
   end else begin : g_follower
      assign sync_out = sync_in;
   end

endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk #(
   parameter int CNT_W   = 16,
   parameter int NUM_CMP = 2,
   parameter bit MASTER  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               sync_in,
   input logic [NUM_CMP-1:0] pwm_raw,
   input logic               sync_out,
   input logic               irq_pulse,
   input logic               irq_flag,
   input logic [CNT_W-1:0]   count
);

   logic f_jump;
   assign f_jump = sync_in && !MASTER;

   // R2: apart from a phase load the counter moves by at most one
   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !f_jump |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                   count == $past(count) - 1'b1));

   // R3: no tick, no movement
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !f_jump) |=> $stable(count));

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_pwm
      // R5: outputs rise only on an upward step and fall only on a downward one
      a_r5_rise_on_up: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwm_raw[gi]) |-> (count > $past(count)));
      a_r5_fall_on_down: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pwm_raw[gi]) |-> (count < $past(count)));
   end

   // R9: the pulse is one cycle wide and always accompanied by the flag
   a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
   a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_flag);

   if (MASTER) begin : g_leader
      // R7: leader sync only at a ticked zero point
      a_r7_sync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
         sync_out |-> (tick && count == '0));
   end

endmodule

bind cpwm_channel cpwm_channel_chk #(
   .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .MASTER(MASTER)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .sync_in(sync_in),
   .pwm_raw(pwm_raw), .sync_out(sync_out), .irq_pulse(irq_pulse),
   .irq_flag(irq_flag), .count(count)
);

// File: tb/test_cpwm_channel.sv
module test_cpwm_channel;

   typedef struct {
      logic [15:0] cnt;
      logic [1:0]  pwm;
      logic        pulse;
      logic        flag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, wr_en = 1'b0, sync_m = 1'b0, sync_f = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  pwm_o, f_pwm;
   logic        sync_o, irq_o, flag_o, f_sync_o, f_irq, f_flag;
   logic [15:0] cnt_o, f_cnt;

   int ntests = 0, nfail = 0, npulse = 0, seen_max = 0;
   bit done = 1'b0;
   exp_t q[$];

   // reference state, built from the requirements
   logic [15:0] m_cnt = 0, m_prd_s = 0, m_prd_a = 0;
   logic [15:0] m_cmp_s[2] = '{0, 0}, m_cmp_a[2] = '{0, 0};
   logic [1:0]  m_pwm = 0;
   bit          m_up = 1'b1, m_pulse = 1'b0, m_flag = 1'b0;
   int          m_evt = 0;

   always #4 clk = ~clk;

   cpwm_channel #(.MASTER(1'b1)) i_cpwm_channel (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sync_in(sync_m), .pwm_raw(pwm_o), .sync_out(sync_o),
      .irq_pulse(irq_o), .irq_flag(flag_o), .count(cnt_o)
   );

   cpwm_channel #(.MASTER(1'b0)) i_cpwm_channel_flw (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sync_in(sync_f), .pwm_raw(f_pwm), .sync_out(f_sync_o),
      .irq_pulse(f_irq), .irq_flag(f_flag), .count(f_cnt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_edge(input bit tk, input bit we, input logic [2:0] ad,
                             input logic [15:0] d);
      logic [15:0] n;
      m_pulse = 1'b0;
      if (tk) begin
         if (m_cnt == 0) begin
            m_prd_a = m_prd_s;
            m_cmp_a = m_cmp_s;
            if (m_evt == 2) begin m_evt = 0; m_pulse = 1'b1; end
            else m_evt++;
         end
         n = m_cnt;
         if (m_prd_a != 0) begin
            if (m_up) begin
               if (m_cnt >= m_prd_a) begin n = m_cnt - 1; m_up = 1'b0; end
               else n = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin n = 1; m_up = 1'b1; end
               else n = m_cnt - 1;
            end
         end
         if (n != m_cnt)
            for (int i = 0; i < 2; i++)
               if (n == m_cmp_a[i] && m_cmp_a[i] != 0 && m_cmp_a[i] <= m_prd_a)
                  m_pwm[i] = (n > m_cnt);
         m_cnt = n;
      end
      if (m_pulse) m_flag = 1'b1;
      else if (we && ad == 3'd4) m_flag = 1'b0;
      if (we && ad == 3'd0) m_prd_s = d;
      if (we && ad == 3'd1) m_cmp_s[0] = d;
      if (we && ad == 3'd2) m_cmp_s[1] = d;
   endtask

   // driver: one clock cycle of stimulus, expectation pushed for the monitor
   task automatic cyc(input bit tk, input bit sy = 0, input bit fs = 0,
                      input bit we = 0, input logic [2:0] ad = 0,
                      input logic [15:0] d = 0);
      exp_t e;
      @(negedge clk);
      tick = tk; sync_m = sy; sync_f = fs; wr_en = we; wr_addr = ad; wr_data = d;
      #1;
      chk("R7 leader sync_out", int'(sync_o), int'(tk && m_cnt == 0));
      chk("R8 follower sync pass", int'(f_sync_o), int'(fs));
      model_edge(tk, we, ad, d);
      @(posedge clk);
      #1;
      e.cnt = m_cnt; e.pwm = m_pwm; e.pulse = m_pulse; e.flag = m_flag;
      q.push_back(e);
      if (int'(cnt_o) > seen_max) seen_max = int'(cnt_o);
      if (irq_o) npulse++;
   endtask

   task automatic wr(input logic [2:0] ad, input logic [15:0] d);
      cyc(0, 0, 0, 1, ad, d);
   endtask

   task automatic run_period();
      int g = 0;
      while (cnt_o == 0 && g < 100) begin cyc(1); cyc(0); g++; end
      while (cnt_o != 0 && g < 400) begin cyc(1); cyc(0); g++; end
   endtask

   // monitor: compares each expected item against the outputs
   initial begin
      exp_t e;
      forever begin
         wait (q.size() != 0);
         e = q.pop_front();
         chk("R2 count", int'(cnt_o), int'(e.cnt));
         chk("R5 pwm outputs", int'(pwm_o), int'(e.pwm));
         chk("R9 irq pulse", int'(irq_o), int'(e.pulse));
         chk("R9 irq flag", int'(flag_o), int'(e.flag));
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         nfail++; ntests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset count", int'(cnt_o), 0);
      chk("R1 reset pwm", int'(pwm_o), 0);
      chk("R1 reset irq", int'(irq_o), 0);
      chk("R1 reset flag", int'(flag_o), 0);
      chk("R1 reset sync", int'(sync_o), 0);

      wr(3'd0, 16'd5); wr(3'd1, 16'd2); wr(3'd2, 16'd4);
      seen_max = 0;
      repeat (3) run_period();
      chk("R2 peak reached", seen_max, 5);

      // R10: leader ignores sync_in mid climb
      for (int g = 0; g < 40 && !(cnt_o == 3 && m_up); g++) cyc(1);
      cyc(1, 1);
      chk("R10 leader ignores sync", int'(cnt_o), 4);
      // R3: idle cycle keeps the count
      cyc(0);
      chk("R3 hold without tick", int'(cnt_o), 4);

      // R4: new peak waits for the zero point
      wr(3'd0, 16'd3);
      seen_max = 0;
      for (int g = 0; g < 40 && cnt_o != 0; g++) cyc(1);
      chk("R4 old peak finishes", seen_max, 5);
      seen_max = 0;
      run_period();
      chk("R4 new peak applied", seen_max, 3);

      // R5: compare equal to peak only sets
      wr(3'd1, 16'd3); wr(3'd2, 16'd3);
      repeat (2) run_period();
      chk("R5 compare at peak latches high", int'(pwm_o), 3);
      // R6: zero and out-of-range compares hold the outputs
      wr(3'd1, 16'd0); wr(3'd2, 16'd7);
      repeat (2) run_period();
      chk("R6 no match holds outputs", int'(pwm_o), 3);
      wr(3'd1, 16'd1); wr(3'd2, 16'd2);
      repeat (2) run_period();
      chk("R5 cleared on down count", int'(pwm_o), 0);

      // R9: decimation and flag clear
      npulse = 0;
      repeat (6) run_period();
      chk("R9 pulses per six zero points", npulse, 2);
      chk("R9 flag sticky", int'(flag_o), 1);
      wr(3'd4, 16'd0);
      chk("R9 flag cleared by write", int'(flag_o), 0);

      // R8: follower phase load and upward continuation
      wr(3'd3, 16'd2);
      cyc(1, 0, 1);
      chk("R8 follower phase load", int'(f_cnt), 2);
      cyc(1);
      chk("R8 follower counts up", int'(f_cnt), 3);

      wait (q.size() == 0);
      #20;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

endmodule